// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a two-channel serial audio stream into parallel samples. The stream arrives on three lines: a bit clock, a word-select line and a data line. Each frame yields one left sample and one right sample. Both come out as 24-bit two's-complement words, presented together with a one-cycle strobe. The three external lines are brought into a fast system clock through two-flop synchronisers. The edges of the bit clock are detected in that clock domain, so the bit clock may run in bursts or stop at any point.

A 2-bit format input picks one of four framing styles. Right-justified, I2S and left-justified framing use word-select levels and rising-edge sampling. Pulse-framed DSP style uses a word-select pulse and falling-edge sampling. A word-length input picks 16, 18, 20 or 24 bits. A packed option fits two 16-bit words into a 32-clock frame.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst_ni` is low and after it is released, `left_o` and `right_o` are zero and `valid_o` is low until the first complete pair.
- R2: With `fmt_i` = 2'b10, word-select high marks the left word and low marks the right word. The MSB is the bit sampled on the first rising bit-clock edge after a word-select change.
- R3: With `fmt_i` = 2'b01, word-select low marks the left word and high marks the right word. The MSB is sampled on the second rising bit-clock edge after a word-select change.
- R4: With `fmt_i` = 2'b00, the word is always 16 bits and ignores `wlen_i`. The same word-select polarity as R2 applies, and the MSB is sampled on the 17th rising edge after a word-select change.
- R5: With `fmt_i` = 2'b11, data is sampled on falling bit-clock edges. Each word starts on the first falling edge where word-select is low after a high pulse. Channels alternate per pulse, and the first pulse after reset starts a left word.
- R6: `wlen_i` selects the word length: 2'b00 = 16, 2'b01 = 18, 2'b10 = 20, 2'b11 = 24 bits. Words arrive MSB first and are placed left-aligned in the 24-bit outputs, with zeros in the unused LSBs.
- R7: Data bits that follow the last bit of the selected word length within a half-frame have no effect on the outputs.
- R8: With `packed_i` high in format 2'b00 or 2'b10, each half-frame holds exactly one 16-bit word. Its MSB is sampled on the first rising edge after the word-select change, and `wlen_i` is ignored.
- R9: `valid_o` pulses high for one system clock when a right word completes and a left word completed since the previous right word. A right word without a preceding left word is dropped with no pulse.
- R10: Only bit-clock edges advance reception. A pause of the bit clock at any level in the middle of a word does not change the received values. The system clock must run at least four times faster than the bit clock.
- R11: `left_o` and `right_o` change only in the cycle where `valid_o` is high, and otherwise hold the last delivered pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| ws_i | input | 1 | Word-select / frame pulse (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP pulse |
| wlen_i | input | 2 | Word length: 00=16, 01=18, 10=20, 11=24 |
| packed_i | input | 1 | 32-clock frame, 16-bit words (formats 00 and 10) |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The bench drives every format at several word lengths with asymmetric patterns and all-ones filler after each word. A design that placed the MSB one bit early or late would come out shifted by a factor of two. A design that kept reading past the word length would show ones in the padding. Directed cases cover four situations. A bit clock frozen mid-word would expose a design that counts system clocks instead of edges. A bare right half after a format change would expose a design that pulses with a stale or empty left word. A DSP pulse right after reset would expose inverted channel tracking. Finally, the outputs must hold through idle periods.

// File: rtl/asrx_pkg.sv
`timescale 1ns/1ps
package asrx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int LEN_W    = 5;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  function automatic logic [LEN_W-1:0] len_of(input logic [1:0] code);
    case (code)
      2'b00:   len_of = LEN_W'(16);
      2'b01:   len_of = LEN_W'(18);
      2'b10:   len_of = LEN_W'(20);
      default: len_of = LEN_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/asrx_sync.sv
`timescale 1ns/1ps
module asrx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/asrx_edge.sv
`timescale 1ns/1ps
module asrx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic fall_sel_i,
  output logic smp_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= bclk_i;
  end

  logic rise, fall;
  assign rise  = bclk_i & ~prev_q;
  assign fall  = ~bclk_i & prev_q;
  assign smp_o = fall_sel_i ? fall : rise;

  // R10
  smp_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_o |=> !smp_o);
endmodule

// File: rtl/asrx_framer.sv
`timescale 1ns/1ps
module asrx_framer
  import asrx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             ws_i,
  input  fmt_e             fmt_i,
  input  logic             packed_i,
  input  logic [1:0]       wlen_i,
  output logic             cap_en_o,
  output logic             cap_first_o,
  output logic             cap_last_o,
  output logic             chan_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int               WIN_W   = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             ws_last_q, chan_q, dsp_next_q;

  logic             dsp, trans, chan_ws, chan_cur, in_win;
  logic [CNT_W-1:0] start, idx;
  logic [WIN_W-1:0] win_end;
  logic [LEN_W-1:0] eff_len;

  always_comb begin
    dsp = (fmt_i == FMT_DSP);
    if (fmt_i == FMT_RJ || (packed_i && fmt_i == FMT_LJ)) eff_len = LEN_W'(16);
    else                                                  eff_len = len_of(wlen_i);
    case (fmt_i)
      FMT_RJ:  start = packed_i ? '0 : CNT_W'(16);
      FMT_I2S: start = CNT_W'(1);
      default: start = '0;
    endcase
    trans    = !dsp && (ws_i != ws_last_q);
    idx      = trans ? '0 : cnt_q;
    chan_ws  = (fmt_i == FMT_I2S) ? ws_i : ~ws_i; // 1 = right
    chan_cur = trans ? chan_ws : chan_q;
    win_end  = {1'b0, start} + WIN_W'(eff_len);
    in_win   = ({1'b0, idx} >= {1'b0, start}) && ({1'b0, idx} < win_end);
  end

  assign cap_en_o    = smp_i && in_win && !(dsp && ws_i);
  assign cap_first_o = cap_en_o && (idx == start);
  assign cap_last_o  = cap_en_o && ({1'b0, idx} == win_end - WIN_W'(1));
  assign chan_o      = chan_cur;
  assign len_o       = eff_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= CNT_MAX;
      ws_last_q  <= 1'b0;
      chan_q     <= 1'b1;
      dsp_next_q <= 1'b0;
    end else if (smp_i) begin
      ws_last_q <= ws_i;
      if (dsp && ws_i) begin
        cnt_q <= '0;
        if (!ws_last_q) begin
          chan_q     <= dsp_next_q;
          dsp_next_q <= ~dsp_next_q;
        end
      end else begin
        cnt_q  <= (idx == CNT_MAX) ? CNT_MAX : idx + CNT_W'(1);
        chan_q <= chan_cur;
      end
    end
  end
endmodule

// File: rtl/asrx_assembler.sv
`timescale 1ns/1ps
module asrx_assembler
  import asrx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_en_i,
  input  logic                cap_first_i,
  input  logic                cap_last_i,
  input  logic                chan_i,
  input  logic                bit_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] sh_q, sh_d, word, left_hold_q;
  logic [LEN_W-1:0]    shamt;
  logic                left_ok_q;

  always_comb begin
    sh_d  = cap_first_i ? {{(SAMPLE_W-1){1'b0}}, bit_i} : {sh_q[SAMPLE_W-2:0], bit_i};
    shamt = LEN_W'(SAMPLE_W) - len_i;
    word  = sh_d << shamt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      left_hold_q <= '0;
      left_ok_q   <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_en_i) sh_q <= sh_d;
      if (cap_last_i) begin
        if (!chan_i) begin
          left_hold_q <= word;
          left_ok_q   <= 1'b1;
        end else begin
          left_ok_q <= 1'b0;
          if (left_ok_q) begin
            left_o  <= left_hold_q;
            right_o <= word;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  // checker state: bits gathered in the current word
  logic [LEN_W:0] bits_q;
  logic           armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q  <= '0;
      armed_q <= 1'b0;
    end else if (cap_en_i) begin
      bits_q  <= cap_first_i ? (LEN_W+1)'(1) : bits_q + (LEN_W+1)'(1);
      armed_q <= cap_first_i ? !cap_last_i : (armed_q && !cap_last_i);
    end
  end

  // R6
  word_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_last_i && !cap_first_i && armed_q) |-> (bits_q + (LEN_W+1)'(1) == {1'b0, len_i}));

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bclk_i,
  input  logic        ws_i,
  input  logic        sdata_i,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  wlen_i,
  input  logic        packed_i,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o
);
  logic [2:0] raw, synced;
  logic       bclk_s, ws_s, sd_s, smp;
  fmt_e       fmt;

  assign raw = {sdata_i, ws_i, bclk_i};
  assign {sd_s, ws_s, bclk_s} = synced;
  assign fmt = fmt_e'(fmt_i);

  asrx_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  asrx_edge edge_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bclk_i(bclk_s),
    .fall_sel_i(fmt == FMT_DSP), .smp_o(smp)
  );

  logic             cap_en, cap_first, cap_last, chan;
  logic [LEN_W-1:0] len;

  asrx_framer #(.CNT_W(CNT_W)) framer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp), .ws_i(ws_s),
    .fmt_i(fmt), .packed_i(packed_i), .wlen_i(wlen_i),
    .cap_en_o(cap_en), .cap_first_o(cap_first), .cap_last_o(cap_last),
    .chan_o(chan), .len_o(len)
  );

  asrx_assembler asm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_en_i(cap_en), .cap_first_i(cap_first),
    .cap_last_i(cap_last), .chan_i(chan), .bit_i(sd_s), .len_i(len),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );
endmodule

// File: tb/audio_serial_rx_tb_top.sv
`timescale 1ns/1ps
module audio_serial_rx_tb_top;
  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        rst_ni, bclk, ws, sd, pk;
  logic [1:0]  fmt, wl;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  audio_serial_rx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bclk_i(bclk), .ws_i(ws), .sdata_i(sd),
    .fmt_i(fmt), .wlen_i(wl), .packed_i(pk),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [1:0]  w;
    logic        p;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 2'b11, 1'b0, 24'h123456, 24'hA5C3E1},
    '{2'b10, 2'b00, 1'b0, 24'h008001, 24'h007FFE},
    '{2'b10, 2'b01, 1'b0, 24'h02ABCD, 24'h015432},
    '{2'b10, 2'b10, 1'b0, 24'h0FEDCB, 24'h001234},
    '{2'b01, 2'b11, 1'b0, 24'h800000, 24'h7FFFFF},
    '{2'b01, 2'b00, 1'b0, 24'h00C0DE, 24'h001234},
    '{2'b01, 2'b10, 1'b0, 24'h0ABCDE, 24'h054321},
    '{2'b00, 2'b11, 1'b0, 24'h00BEEF, 24'h000F0F},
    '{2'b00, 2'b00, 1'b1, 24'h001357, 24'h00FDB9},
    '{2'b10, 2'b11, 1'b1, 24'h002468, 24'h009ACE},
    '{2'b11, 2'b11, 1'b0, 24'hF00F5A, 24'h0A0B0C},
    '{2'b11, 2'b01, 1'b0, 24'h03FFFF, 24'h000001}
  };

  int nvec = 0, miss = 0, npulse = 0;
  bit done = 0;

  always @(negedge clk_i) if (rst_ni && valid_o) npulse++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, miss);
      $finish;
    end
  endtask

  function automatic int blen(input logic [1:0] m, input logic [1:0] w, input logic p);
    if (m == 2'b00 || p) return 16;
    case (w)
      2'b00: return 16;
      2'b01: return 18;
      2'b10: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int exp_word(input logic [23:0] raw, input int len);
    logic [23:0] msk;
    msk = (len == 24) ? 24'hFFFFFF : ((24'd1 << len) - 24'd1);
    return int'((raw & msk) << (24 - len));
  endfunction

  function automatic string rname(input logic [1:0] m, input logic p);
    if (p) return "R8";
    case (m)
      2'b00: return "R4";
      2'b01: return "R3";
      2'b10: return "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic slot(input logic w, input logic d, input logic dsp);
    if (dsp) begin
      bclk = 1'b1; ws = w; sd = d;
      repeat (4) @(negedge clk_i);
      bclk = 1'b0;
      repeat (4) @(negedge clk_i);
    end else begin
      bclk = 1'b0; ws = w; sd = d;
      repeat (4) @(negedge clk_i);
      bclk = 1'b1;
      repeat (4) @(negedge clk_i);
    end
  endtask

  task automatic idle_half(input logic [1:0] m);
    for (int k = 0; k < 32; k++) slot(m == 2'b01, 1'b1, m == 2'b11);
  endtask

  task automatic send_frame(input logic [1:0] m, input logic [1:0] w, input logic p,
                            input logic [23:0] l, input logic [23:0] r, input int stall_k);
    int len, n;
    logic wsv, dv;
    logic [23:0] word;
    len = blen(m, w, p);
    n   = p ? 16 : 32;
    for (int h = 0; h < 2; h++) begin
      word = h ? r : l;
      for (int k = 0; k < n; k++) begin
        if (h == 0 && k == stall_k) repeat (40) @(negedge clk_i);
        case (m)
          2'b01:   wsv = (h == 1);
          2'b11:   wsv = (k == 0);
          default: wsv = (h == 0);
        endcase
        case (m)
          2'b10:   dv = (k < len) ? word[len-1-k] : 1'b1;
          2'b00:   dv = (k >= n-16) ? word[15-(k-(n-16))] : 1'b1;
          default: dv = (k >= 1 && k <= len) ? word[len-k] : 1'b1;
        endcase
        slot(wsv, dv, m == 2'b11);
      end
    end
  endtask

  task automatic run_vec(input vec_t v, input int stall_k, input string tag);
    int p0, len;
    fmt = v.m; wl = v.w; pk = v.p;
    idle_half(v.m);
    p0 = npulse;
    send_frame(v.m, v.w, v.p, v.l, v.r, stall_k);
    repeat (12) @(negedge clk_i);
    len = blen(v.m, v.w, v.p);
    chk("R9", {tag, " pulse count"}, npulse - p0, 1);
    chk(tag, "left", int'(left_o), exp_word(v.l, len));
    chk(tag, "right", int'(right_o), exp_word(v.r, len));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    miss++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    bclk = 0; ws = 0; sd = 0; fmt = 2'b10; wl = 2'b11; pk = 0;
    do_reset();
    // R1 reset state
    chk("R1", "left", int'(left_o), 0);
    chk("R1", "right", int'(right_o), 0);
    chk("R1", "valid", int'(valid_o), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("%s/R6%s vec%0d", rname(VECS[i].m, VECS[i].p),
                      (blen(VECS[i].m, VECS[i].w, VECS[i].p) < 24) ? "/R7" : "", i);
      run_vec(VECS[i], -1, tag);
    end

    // R10 bit clock frozen mid-word
    run_vec('{2'b10, 2'b11, 1'b0, 24'h5A5A5A, 24'h3C3C3C}, 10, "R10 stalled");

    // R9 lone right halves must not pulse; R11 outputs hold
    begin
      int p0;
      fmt = 2'b01; wl = 2'b11; pk = 0;
      p0 = npulse;
      idle_half(2'b01);
      idle_half(2'b01);
      repeat (12) @(negedge clk_i);
      chk("R9", "orphan right pulses", npulse - p0, 0);
      chk("R11", "left hold", int'(left_o), 24'h5A5A5A);
      chk("R11", "right hold", int'(right_o), 24'h3C3C3C);
    end

    // R5 first pulse after reset is left
    do_reset();
    chk("R1", "left after re-reset", int'(left_o), 0);
    run_vec('{2'b11, 2'b10, 1'b0, 24'h0C3A51, 24'h0F00F1}, -1, "R5 first-after-reset");

    finish_run();
  end
endmodule